// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block turns one parallel character into an asynchronous serial frame on a single output line. A host places a character on `data_i` and raises `send_i`. When the block is idle it accepts the request and drives a frame: a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. `busy_o` is high while the frame is on the line.

A divisor input sets the bit period in system clocks, so one block covers any bit rate the clock allows. Three control inputs select the character length (5 to 9 bits), the parity policy (none, odd, even, mark, space) and the stop length (1, 1.5 or 2 bits). The half-bit part of a 1.5-bit stop comes from a shorter count of the same bit timer. The block samples the divisor, the controls and the character at the moment it accepts a frame. Input changes after that point have no effect until the next frame.

Top module: `async_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx_o` is 1 and `busy_o` is 0.
- R2: A `send_i` sampled high at a clock edge while idle is accepted. From the next cycle `busy_o` is 1 and `tx_o` carries a 0 start bit for one bit period.
- R3: Data bits follow the start bit with the least significant bit first. `len_i` code k (0 to 4) sends k+5 bits, and codes 5 to 7 send 9 bits.
- R4: `par_i` code 1 (odd) sends a parity bit of 1 when the sent data bits hold an even number of ones and 0 otherwise. Code 2 (even) sends the inverse of that.
- R5: `par_i` code 3 (mark) always sends 1 and code 4 (space) always sends 0. Code 0 and codes 5 to 7 send no parity bit.
- R6: The stop period is 1. `stop_i` code 0 lasts one bit period. Code 1 lasts one bit period plus floor(div/2)+1 clocks. Codes 2 and 3 last two bit periods.
- R7: `busy_o` stays 1 for exactly the frame length and falls on the edge where the stop period ends, with `tx_o` held at 1.
- R8: A `send_i` during a frame is ignored. Changes to `data_i`, `div_i`, `len_i`, `par_i` or `stop_i` during a frame do not alter that frame.
- R9: One bit period is `div_i`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W (16) | Bit period minus one, in clocks |
| data_i | input | DATA_W (9) | Character to send |
| send_i | input | 1 | Send request |
| len_i | input | 3 | Character length code |
| par_i | input | 3 | Parity policy code |
| stop_i | input | 2 | Stop length code |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench sweeps every combination of length, parity and stop code, using three characters: alternating ones and zeros, a sparse pattern with a single one, and a pattern with all bits set. These cover both parity outcomes and show whether bits come out in the wrong order. Each frame is compared clock by clock against a waveform the bench computes from the requirements. A mismatch is reported against the start, data, parity or stop region, or against the busy window. Every frame injects a second send request and scrambles every input partway through, so any leak of mid-frame input shows up as a waveform difference. Divisors of 2, 5 and 8 exercise odd and even half-bit rounding in the 1.5-bit stop.

// File: rtl/async_frame_tx_pkg.sv
package async_frame_tx_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DATA,
        SQ_PARITY,
        SQ_STOP,
        SQ_HALF
    } seq_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

endpackage

// File: rtl/aft_bit_timer.sv
module aft_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             half_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        t_d    = t_q;
        limit  = half_i ? (div_i >> 1) : div_i;
        tick_o = (t_q.cnt == limit);
        if (restart_i || tick_o) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/aft_parity_gen.sv
module aft_parity_gen
    import async_frame_tx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int MIN_W  = 5
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [3:0]        nbits_i,
    input  logic [2:0]        mode_i,
    output logic              en_o,
    output logic              bit_o
);

    logic [DATA_W-1:0] masked;
    logic              odd_ones;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = data_i[i] && (i < int'(nbits_i));
        end
        odd_ones = ^masked;
        en_o  = 1'b1;
        bit_o = 1'b1;
        unique case (mode_i)
            PAR_ODD:   bit_o = ~odd_ones;
            PAR_EVEN:  bit_o = odd_ones;
            PAR_MARK:  bit_o = 1'b1;
            PAR_SPACE: bit_o = 1'b0;
            default: begin
                en_o  = 1'b0;
                bit_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/aft_sequencer.sv
module aft_sequencer
    import async_frame_tx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int MIN_W  = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              send_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [3:0]        nbits_i,
    input  logic              par_en_i,
    input  logic              par_bit_i,
    input  logic [1:0]        stop_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              tick_i,
    output logic              restart_o,
    output logic              half_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              tx_o,
    output logic              busy_o
);

    typedef struct packed {
        seq_state_e        state;
        logic              tx;
        logic              busy;
        logic [DATA_W-1:0] shift;
        logic [3:0]        idx;
        logic [3:0]        last;
        logic              par_en;
        logic              par_bit;
        logic [1:0]        stop;
        logic              second;
        logic [DIV_W-1:0]  div;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        restart_o = 1'b0;
        unique case (s_q.state)
            SQ_IDLE: begin
                s_d.tx   = 1'b1;
                s_d.busy = 1'b0;
                if (send_i) begin
                    restart_o   = 1'b1;
                    s_d.state   = SQ_START;
                    s_d.tx      = 1'b0;
                    s_d.busy    = 1'b1;
                    s_d.shift   = data_i;
                    s_d.idx     = '0;
                    s_d.last    = nbits_i - 4'd1;
                    s_d.par_en  = par_en_i;
                    s_d.par_bit = par_bit_i;
                    s_d.stop    = stop_i;
                    s_d.second  = 1'b0;
                    s_d.div     = div_i;
                end
            end
            SQ_START: begin
                if (tick_i) begin
                    s_d.state = SQ_DATA;
                    s_d.tx    = s_q.shift[0];
                    s_d.shift = s_q.shift >> 1;
                end
            end
            SQ_DATA: begin
                if (tick_i) begin
                    if (s_q.idx == s_q.last) begin
                        if (s_q.par_en) begin
                            s_d.state = SQ_PARITY;
                            s_d.tx    = s_q.par_bit;
                        end else begin
                            s_d.state = SQ_STOP;
                            s_d.tx    = 1'b1;
                        end
                    end else begin
                        s_d.idx   = s_q.idx + 4'd1;
                        s_d.tx    = s_q.shift[0];
                        s_d.shift = s_q.shift >> 1;
                    end
                end
            end
            SQ_PARITY: begin
                if (tick_i) begin
                    s_d.state = SQ_STOP;
                    s_d.tx    = 1'b1;
                end
            end
            SQ_STOP: begin
                s_d.tx = 1'b1;
                if (tick_i) begin
                    if (s_q.stop == STOP_HALF) begin
                        s_d.state = SQ_HALF;
                    end else if (s_q.stop != STOP_ONE && !s_q.second) begin
                        s_d.second = 1'b1;
                    end else begin
                        s_d.state = SQ_IDLE;
                        s_d.busy  = 1'b0;
                    end
                end
            end
            SQ_HALF: begin
                s_d.tx = 1'b1;
                if (tick_i) begin
                    s_d.state = SQ_IDLE;
                    s_d.busy  = 1'b0;
                end
            end
            default: begin
                s_d.state = SQ_IDLE;
                s_d.tx    = 1'b1;
                s_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.state <= SQ_IDLE;
            s_q.tx    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign half_o = (s_q.state == SQ_HALF);
    assign div_o  = s_q.div;
    assign tx_o   = s_q.tx;
    assign busy_o = s_q.busy;

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import async_frame_tx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int MIN_W  = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              send_i,
    input  logic [2:0]        len_i,
    input  logic [2:0]        par_i,
    input  logic [1:0]        stop_i,
    output logic              tx_o,
    output logic              busy_o
);

    localparam int MAX_CODE = DATA_W - MIN_W;

    logic [3:0]       nbits;
    logic             par_en, par_bit;
    logic             restart, half, tick;
    logic [DIV_W-1:0] div_held;

    always_comb begin
        if (int'(len_i) > MAX_CODE) begin
            nbits = 4'(DATA_W);
        end else begin
            nbits = 4'(MIN_W) + 4'(len_i);
        end
    end

    aft_parity_gen #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
        .data_i  (data_i),
        .nbits_i (nbits),
        .mode_i  (par_i),
        .en_o    (par_en),
        .bit_o   (par_bit)
    );

    aft_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .half_i    (half),
        .div_i     (div_held),
        .tick_o    (tick)
    );

    aft_sequencer #(.DATA_W(DATA_W), .MIN_W(MIN_W), .DIV_W(DIV_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .send_i    (send_i),
        .data_i    (data_i),
        .nbits_i   (nbits),
        .par_en_i  (par_en),
        .par_bit_i (par_bit),
        .stop_i    (stop_i),
        .div_i     (div_i),
        .tick_i    (tick),
        .restart_o (restart),
        .half_o    (half),
        .div_o     (div_held),
        .tx_o      (tx_o),
        .busy_o    (busy_o)
    );

endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic send_i,
    input logic tx_o,
    input logic busy_o
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> tx_o);

    // R2
    busy_needs_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(send_i));

    // R2
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !tx_o);

    // R7
    end_in_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (tx_o && $past(tx_o)));

    // R8
    busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tx_o) |=> busy_o);

endmodule

bind async_frame_tx async_frame_tx_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .send_i (send_i),
    .tx_o   (tx_o),
    .busy_o (busy_o)
);

// File: tb/async_frame_tx_tb.sv
`timescale 1ns/1ps
module async_frame_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div = 16'd5;
    logic [8:0]  data = '0;
    logic        send = 1'b0;
    logic [2:0]  len = '0;
    logic [2:0]  par = '0;
    logic [1:0]  stop = '0;
    logic        tx, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    async_frame_tx u_dut (
        .clk_i (clk), .rst_ni (rst_n), .div_i (div), .data_i (data),
        .send_i (send), .len_i (len), .par_i (par), .stop_i (stop),
        .tx_o (tx), .busy_o (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int dv, input logic [8:0] d, input int lc, input int pc, input int sc);
        int nb, pe, pb, ones, per, half, total;
        int bad_s, bad_d, bad_p, bad_t, bad_b;
        int a_s, a_d, a_p, a_t, a_b, e_s, e_d, e_p, e_t, e_b;
        nb = (lc > 4) ? 9 : lc + 5;
        ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        pe = (pc >= 1 && pc <= 4) ? 1 : 0;
        pb = (pc == 1) ? ((ones % 2 == 0) ? 1 : 0) :
             (pc == 2) ? (ones % 2) : (pc == 3) ? 1 : 0;
        per = dv + 1;
        half = dv / 2 + 1;
        total = per * (1 + nb + pe + ((sc == 0 || sc == 1) ? 1 : 2)) + ((sc == 1) ? half : 0);
        bad_s = 0; bad_d = 0; bad_p = 0; bad_t = 0; bad_b = 0;
        a_s = 0; a_d = 0; a_p = 0; a_t = 0; a_b = 0;
        e_s = 0; e_d = 0; e_p = 0; e_t = 0; e_b = 0;
        @(negedge clk);
        div = 16'(dv); data = d; len = 3'(lc); par = 3'(pc); stop = 2'(sc); send = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= total; k++) begin
            int slot, expv, expb;
            // R8: scramble inputs and re-request mid-frame
            if (k == 0) begin
                send = 1'b0; data = ~d; div = 16'(dv + 3);
                len = 3'(lc + 2); par = 3'(pc + 1); stop = 2'(sc + 1);
            end
            if (k == 2 * per) send = 1'b1;
            if (k == 2 * per + 1) send = 1'b0;
            slot = k / per;
            expb = (k < total) ? 1 : 0;
            if (k >= total) expv = 1;
            else if (slot == 0) expv = 0;
            else if (slot - 1 < nb) expv = d[slot - 1];
            else if (pe == 1 && slot - 1 == nb) expv = pb;
            else expv = 1;
            if (busy !== expb[0] && bad_b == 0) begin bad_b = 1; a_b = busy; e_b = expb; end
            if (tx !== expv[0]) begin
                if (k >= total || slot - 1 >= nb + pe) begin
                    if (bad_t == 0) begin bad_t = 1; a_t = tx; e_t = expv; end
                end else if (slot == 0) begin
                    if (bad_s == 0) begin bad_s = 1; a_s = tx; e_s = expv; end
                end else if (slot - 1 < nb) begin
                    if (bad_d == 0) begin bad_d = 1; a_d = tx; e_d = expv; end
                end else begin
                    if (bad_p == 0) begin bad_p = 1; a_p = tx; e_p = expv; end
                end
            end
            @(negedge clk);
        end
        check(bad_s == 0, "R2 start bit", a_s, e_s);
        check(bad_d == 0, "R3 data bits / R9 period / R8 mid-frame inputs", a_d, e_d);
        if (pc == 1 || pc == 2) check(bad_p == 0, "R4 odd/even parity", a_p, e_p);
        else check(bad_p == 0, "R5 mark/space/none parity", a_p, e_p);
        check(bad_t == 0, "R6 stop period", a_t, e_t);
        check(bad_b == 0, "R7 busy window", a_b, e_b);
        check(tx === 1'b1 && busy === 1'b0, "R1 idle after frame", int'(tx), 1);
    endtask

    initial begin
        #25_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [8:0] pats [3];
        pats[0] = 9'h155; pats[1] = 9'h010; pats[2] = 9'h1FF;
        repeat (3) @(negedge clk);
        check(tx === 1'b1, "R1 reset line", int'(tx), 1);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx === 1'b1 && busy === 1'b0, "R1 idle after reset", int'(busy), 0);
        for (int lc = 0; lc < 5; lc++)
            for (int pc = 0; pc < 5; pc++)
                for (int sc = 0; sc < 3; sc++)
                    for (int p = 0; p < 3; p++)
                        run_frame(5, pats[p], lc, pc, sc);
        // R3 clamp, R5 unused parity codes, R6 code 3, R9 other divisors
        run_frame(5, 9'h1A5, 7, 6, 3);
        run_frame(2, 9'h0B3, 3, 1, 1);
        run_frame(8, 9'h0B3, 4, 2, 1);
        run_frame(2, 9'h12C, 1, 4, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule